// File: doc/BRIEF.md
# Multi-Byte Memory Adder

This block is a small sequencer that adds two unsigned multi-byte numbers stored in a byte-wide, single-port synchronous memory. The sum replaces the first operand in memory. Each operand is laid out with its least significant byte at the lowest address. The number of bytes is not a pin: the engine fetches it from a memory location whose address is supplied at start.

A start pulse latches three addresses: the length location, the base of operand A and the base of operand B. The engine then clears its carry and reads the length byte. For each byte it reads B, then reads A, then writes A+B+carry back to A's address. Both pointers move up by one after each byte. When the count is used up the engine raises `done` and holds the final carry on `carry_out`. The memory port has one cycle of read latency: data appears on `mem_rdata` in the cycle after the address is presented with `mem_we` low. There is no streaming interface and no back-pressure. The engine owns the memory port for the whole run, and every pin is a plain control or status signal.

Top module: `madd_engine`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `done`, `mem_we` and `carry_out` are all 0.
- R2: A start accepted while the engine is not busy makes the next cycle a length read: `mem_addr` equals the latched length address and `mem_we` is 0.
- R3: The carry is cleared when a run is accepted. `carry_out` is 0 in the cycle after start, and a stale carry from an earlier run never enters the first byte.
- R4: Each written byte equals (A byte + B byte + carry in) mod 256 and goes to the address of the A byte. The carry out of that addition feeds the next byte.
- R5: Bytes are processed in ascending address order, least significant first. After a run of N bytes, memory at A base..A base+N-1 holds (A + B) mod 2^(8N), little-endian. Writes are never on consecutive cycles.
- R6: A run of N bytes performs exactly N writes, all inside the A region. Operand B and the length byte are left unchanged.
- R7: A length of 0 completes with no memory write and `carry_out` equal to 0. `mem_we` is never high while `done` is high.
- R8: `done` first rises 3N+2 rising edges after the edge that samples start: 2 cycles for the length fetch and 3 cycles per byte.
- R9: `carry_out` equals the carry out of the most significant byte. `done` and `carry_out` stay constant until the next start.
- R10: A start pulse while a run is in progress is ignored. The result, the write count and the completion time are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted when idle or done |
| len_addr | input | AW | Address of the byte that holds the operand length |
| a_base | input | AW | Address of the least significant byte of operand A (the destination) |
| b_base | input | AW | Address of the least significant byte of operand B |
| mem_addr | output | AW | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid one cycle after a read address |
| done | output | 1 | Run complete; held until the next start |
| carry_out | output | 1 | Final carry of the addition |

## Verification
A wrong count shows up at once as a `done` edge that misses the 3N+2 cycle mark, and as a wrong number of writes. A pointer that slips lands a write outside the A region on the first byte it affects. A carry that is not cleared or not propagated corrupts the first byte, or the byte after the first carry, in memory. A bad read phase makes a written byte use the wrong operand. Every such fault is visible at the ports within one byte period (three cycles) of its cause, or at latest at `done`.

// File: rtl/madd_pkg.sv
package madd_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_LEN_RD,
    S_LEN_WT,
    S_RD_B,
    S_RD_A,
    S_WR,
    S_DONE
  } madd_state_e;
endpackage

// File: rtl/madd_ctrl.sv
module madd_ctrl import madd_pkg::*; #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] len_val,
  output madd_state_e   st,
  output logic          busy,
  output logic          done,
  output logic          launch,
  output logic          step
);
  madd_state_e   nx;
  logic [CW-1:0] cnt;

  assign busy   = !(st == S_IDLE || st == S_DONE);
  assign done   = (st == S_DONE);
  assign launch = start && !busy;
  assign step   = (st == S_WR);

  always_comb begin
    nx = st;
    unique case (st)
      S_IDLE:   if (start) nx = S_LEN_RD;
      S_DONE:   if (start) nx = S_LEN_RD;
      S_LEN_RD: nx = S_LEN_WT;
      S_LEN_WT: nx = (len_val == '0) ? S_DONE : S_RD_B;
      S_RD_B:   nx = S_RD_A;
      S_RD_A:   nx = S_WR;
      S_WR:     nx = (cnt == CW'(1)) ? S_DONE : S_RD_B;
      default:  nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      st <= nx;
      if (st == S_LEN_WT) cnt <= len_val;
      else if (step)      cnt <= cnt - CW'(1);
    end
  end
endmodule

// File: rtl/madd_ptrs.sv
module madd_ptrs import madd_pkg::*; #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic          step,
  input  madd_state_e   st,
  input  logic [AW-1:0] len_addr,
  input  logic [AW-1:0] a_base,
  input  logic [AW-1:0] b_base,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] len_q, a_ptr, b_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      a_ptr <= '0;
      b_ptr <= '0;
    end else if (launch) begin
      len_q <= len_addr;
      a_ptr <= a_base;
      b_ptr <= b_base;
    end else if (step) begin
      a_ptr <= a_ptr + AW'(1);
      b_ptr <= b_ptr + AW'(1);
    end
  end

  always_comb begin
    unique case (st)
      S_LEN_RD, S_LEN_WT: addr = len_q;
      S_RD_B:             addr = b_ptr;
      default:            addr = a_ptr;
    endcase
  end
endmodule

// File: rtl/madd_adder.sv
module madd_adder #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          cap_b,
  input  logic          step,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] sum,
  output logic          carry
);
  logic [DW-1:0] b_q;
  logic [DW:0]   full;

  assign full = {1'b0, rdata} + {1'b0, b_q} + {{DW{1'b0}}, carry};
  assign sum  = full[DW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_q   <= '0;
      carry <= 1'b0;
    end else begin
      if (cap_b) b_q <= rdata;
      if (clear)     carry <= 1'b0;
      else if (step) carry <= full[DW];
    end
  end
endmodule

// File: rtl/madd_engine.sv
module madd_engine import madd_pkg::*; #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] len_addr,
  input  logic [AW-1:0] a_base,
  input  logic [AW-1:0] b_base,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          done,
  output logic          carry_out
);
  madd_state_e st;
  logic        busy, launch, step;

  madd_ctrl #(.CW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .len_val(mem_rdata),
    .st(st), .busy(busy), .done(done), .launch(launch), .step(step)
  );

  madd_ptrs #(.AW(AW)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .launch(launch), .step(step), .st(st),
    .len_addr(len_addr), .a_base(a_base), .b_base(b_base), .addr(mem_addr)
  );

  madd_adder #(.DW(DW)) u_add (
    .clk(clk), .rst_n(rst_n), .clear(launch), .cap_b(st == S_RD_A),
    .step(step), .rdata(mem_rdata), .sum(mem_wdata), .carry(carry_out)
  );

  assign mem_we = step;
endmodule

// File: rtl/madd_engine_chk.sv
module madd_engine_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          carry_out,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] len_addr
);
  // R2: length fetched in the cycle after an accepted start
  a_r2_len_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (mem_addr == $past(len_addr) && !mem_we));

  // R3: carry cleared when a run begins
  a_r3_carry_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> !carry_out);

  // R5: writes are separated by read cycles
  a_r5_write_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  // R7: no write while complete
  a_r7_no_write_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_we);

  // R9: result held until the next start
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(carry_out)));
endmodule

bind madd_engine madd_engine_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .carry_out(carry_out), .mem_we(mem_we), .mem_addr(mem_addr),
  .len_addr(len_addr)
);

// File: tb/madd_engine_tb.sv
module madd_engine_tb;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam logic [AW-1:0] LADDR = 16'd250;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] len_addr = LADDR, a_base = '0, b_base = '0;
  logic [AW-1:0] mem_addr;
  logic          mem_we;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          done, carry_out;

  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  int  checks = 0, errors = 0, cycles = 0;
  int  wr_total = 0, wr_bad = 0;
  int  cur_a = 0, cur_n = 0;
  logic exp_cy;

  always #10 clk = ~clk;

  madd_engine #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .len_addr(len_addr),
    .a_base(a_base), .b_base(b_base), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done),
    .carry_out(carry_out)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    mem_rdata <= mem[mem_addr[7:0]];
    if (mem_we) begin
      mem[mem_addr[7:0]] <= mem_wdata;
      wr_total <= wr_total + 1;
      if (int'(mem_addr) < cur_a || int'(mem_addr) >= cur_a + cur_n)
        wr_bad <= wr_bad + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void model(input int a, input int b, input int n);
    logic [8:0] s;
    logic c = 1'b0;
    for (int i = 0; i < 256; i++) exp_mem[i] = mem[i];
    for (int i = 0; i < n; i++) begin
      s = {1'b0, mem[a+i]} + {1'b0, mem[b+i]} + {8'd0, c};
      exp_mem[a+i] = s[7:0];
      c = s[8];
    end
    exp_cy = c;
  endfunction

  // one run; stray_at > 0 pulses start again at that count while busy
  task automatic run(input int a, input int b, input int n, input int stray_at);
    int cnt, w0, b0;
    @(negedge clk);
    mem[LADDR[7:0]] = 8'(n);
    a_base = 16'(a); b_base = 16'(b);
    cur_a = a; cur_n = n;
    model(a, b, n);
    w0 = wr_total; b0 = wr_bad;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(mem_addr == LADDR && !mem_we, "R2", int'(mem_addr), int'(LADDR));
    chk(carry_out == 1'b0, "R3", int'(carry_out), 0);
    cnt = 1;
    while (!done && cnt < 2000) begin
      start = (stray_at > 0 && cnt == stray_at);
      @(negedge clk);
      cnt++;
    end
    start = 1'b0;
    // done rises 3n+2 edges after the start edge, seen at negedge count 3n+3
    chk(cnt == 3 * n + 3, "R8", cnt, 3 * n + 3);
    chk(wr_total - w0 == n, "R6", wr_total - w0, n);
    chk(wr_bad == b0, "R6", wr_bad - b0, 0);
    for (int i = 0; i < 256; i++)
      if (mem[i] !== exp_mem[i]) begin
        chk(1'b0, (i >= a && i < a + n) ? "R4/R5" : "R6", int'(mem[i]), int'(exp_mem[i]));
        break;
      end
    chk(1'b1, "R5", 0, 0);
    chk(carry_out == exp_cy, "R9", int'(carry_out), int'(exp_cy));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(done && carry_out == exp_cy && !mem_we, "R9", int'({done, carry_out}), int'({1'b1, exp_cy}));
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7);
    @(negedge clk);
    chk(!done && !mem_we && !carry_out, "R1", int'({done, mem_we, carry_out}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !mem_we && !carry_out, "R1", int'({done, mem_we, carry_out}), 0);

    // R7: zero length
    run(10, 140, 0, 0);
    chk(carry_out == 1'b0, "R7", int'(carry_out), 0);

    // R4/R9: single byte with carry out
    mem[20] = 8'hFF; mem[150] = 8'h01;
    run(20, 150, 1, 0);
    chk(mem[20] == 8'h00 && carry_out, "R4", int'(mem[20]), 0);

    // R3: stale carry must not enter the next run
    mem[30] = 8'h10; mem[160] = 8'h20;
    run(30, 160, 1, 0);
    chk(mem[30] == 8'h30, "R3", int'(mem[30]), 8'h30);

    // R5: carry ripples through four bytes, ascending order
    mem[40] = 8'hFF; mem[41] = 8'hFF; mem[42] = 8'hFF; mem[43] = 8'h7F;
    mem[170] = 8'h01; mem[171] = 8'h00; mem[172] = 8'h00; mem[173] = 8'h00;
    run(40, 170, 4, 0);
    chk({mem[43], mem[42], mem[41], mem[40]} == 32'h8000_0000, "R5",
        int'({mem[43], mem[42], mem[41], mem[40]}), 32'h8000_0000);

    // R10: stray start mid-run
    run(50, 180, 6, 5);

    // random runs
    for (int t = 0; t < 12; t++) begin
      int a, b, n;
      a = int'($urandom_range(0, 60));
      b = 128 + int'($urandom_range(0, 60));
      n = int'($urandom_range(1, 12));
      for (int i = 0; i < n; i++) begin
        mem[a+i] = 8'($urandom);
        mem[b+i] = 8'($urandom);
      end
      run(a, b, n, (t % 4 == 0) ? 7 : 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule